// File: doc/BRIEF.md
# Dual-Bank Interrupt Controller

This block collects level-sensitive interrupt request lines from peripherals and external pins and presents them to a processor core as two request outputs: a normal request and a fast request. Each output comes from its own bank of registers. A bank holds an enable mask and shows software three views of its sources: the live raw lines, the mask, and the masked status. A bank's request output is high while any bit of its status is set. There is no priority encoder and no vector: the handler reads the status word and finds the source itself.

Both banks number their sources the same way. Twenty-two common source lines occupy bits 1 to 22 of each bank. Bit 23 is wired to a different line in each bank: the PWM trip line in the normal bank and the PWM sync line in the fast bank. Bit 0 of each bank is a summary bit that is high whenever any of that bank's bits 1 to 23 is high. Software changes the mask through a set port and a separate clear port. It therefore never needs an atomic read-modify-write to enable or mask one source.

Registers sit on a simple 32-bit bus with single-cycle write strobes and a registered read port. Request lines are not latched here. Each raw bit follows its line and drops when the peripheral withdraws its request.

Top module: `dual_bank_intc`

## Requirements
- R1: Raw register bit k (k = 1..22) equals src_i[k-1] in both banks. Bit 23 equals pwm_trip_i in the normal bank and pwm_sync_i in the fast bank. Bit 0 is the OR of bits 1..23 of the same bank. Raw bits follow the inputs and are never latched.
- R2: After reset both enable masks are zero, both status words read zero and both request outputs are low, whatever the source lines are doing.
- R3: A bus write to a bank's enable register ORs bits 23:0 of the write data into that mask. Written zeros leave mask bits unchanged, and the mask holds when no write targets it.
- R4: A bus write to a bank's clear register clears every mask bit written as one and leaves every bit written as zero unchanged.
- R5: A bank's status register reads raw AND enable.
- R6: norm_req_o is the OR of the normal bank's status bits, and fast_req_o is the OR of the fast bank's status bits. Both are combinational from the source lines and the mask.
- R7: Byte addresses are fixed. The normal bank has status at 0x000, raw at 0x004, enable at 0x008 and clear at 0x00C. The fast bank uses the same order at 0x100, 0x104, 0x108 and 0x10C.
- R8: Read data bits 31:24 are zero. Reads of a clear register return zero. Writes to status or raw registers are ignored. Any address other than the eight in R7 reads zero, and writes to it are ignored.
- R9: bus_rdata_o loads on the clock edge at which bus_rd_i is high and holds its value otherwise. It resets to zero.
- R10: A write to one bank never changes the other bank's enable mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_i | input | 22 | Common level request lines, source bits 1..22 |
| pwm_trip_i | input | 1 | Level request at bit 23 of the normal bank |
| pwm_sync_i | input | 1 | Level request at bit 23 of the fast bank |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_addr_i | input | 12 | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| norm_req_o | output | 1 | Normal interrupt request to the core |
| fast_req_o | output | 1 | Fast interrupt request to the core |

## Verification
The hardest cases to reach are those where the two banks must disagree. Bit 23 carries a different line in each bank. The summary bit 0, when it is the only enabled bit, has to raise a request from a source whose own enable bit is off. Random stimulus rarely builds either mask state, so directed steps enable only bit 23 in the fast bank and toggle the trip and sync lines one at a time, then enable only bit 0 and drive one common line. Random set and clear writes with sparse masks, reads of random and illegal addresses, and fresh source patterns every cycle then cover the general space against a bench model of both masks.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int DATA_W = 32;
  localparam int BANKS  = 2;

  typedef enum logic [1:0] {
    REG_STAT = 2'd0,
    REG_RAW  = 2'd1,
    REG_EN   = 2'd2,
    REG_CLR  = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic     hit;
    logic     fast;
    reg_sel_e sel;
  } bus_dec_t;
endpackage

// File: rtl/intc_src_map.sv
module intc_src_map #(
  parameter int N_COMMON = 22,
  localparam int W = N_COMMON + 2
) (
  input  logic [N_COMMON-1:0] src_i,
  input  logic                pwm_trip_i,
  input  logic                pwm_sync_i,
  output logic [W-1:0]        raw_norm_o,
  output logic [W-1:0]        raw_fast_o
);
  logic [W-2:0] lines_norm;
  logic [W-2:0] lines_fast;

  always_comb begin
    lines_norm = {pwm_trip_i, src_i};
    lines_fast = {pwm_sync_i, src_i};
    raw_norm_o = {lines_norm, |lines_norm};
    raw_fast_o = {lines_fast, |lines_fast};
  end
endmodule

// File: rtl/intc_bank.sv
module intc_bank #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw_i,
  input  logic         set_we_i,
  input  logic         clr_we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] en_o,
  output logic [W-1:0] stat_o,
  output logic         req_o
);
  logic [W-1:0] en_q;
  logic [W-1:0] en_d;
  logic         en_ce;

  always_comb begin
    en_ce = set_we_i | clr_we_i;
    en_d  = en_q;
    if (set_we_i)      en_d = en_q | wdata_i;
    else if (clr_we_i) en_d = en_q & ~wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (en_ce) en_q <= en_d;
  end

  always_comb begin
    en_o   = en_q;
    stat_o = raw_i & en_q;
    req_o  = |stat_o;
  end

  assert_set_ones_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (set_we_i && !clr_we_i) |=> (((en_q & $past(wdata_i)) == $past(wdata_i)) &&
                                 ((en_q & ~$past(wdata_i)) == ($past(en_q) & ~$past(wdata_i)))));

  assert_clear_ones_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we_i && !set_we_i) |=> (((en_q & $past(wdata_i)) == '0) &&
                                 ((en_q & ~$past(wdata_i)) == ($past(en_q) & ~$past(wdata_i)))));

  assert_mask_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_we_i && !clr_we_i) |=> $stable(en_q));

  assert_req_needs_line_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req_o |-> (|raw_i));
endmodule

// File: rtl/dual_bank_intc.sv
module dual_bank_intc
  import intc_pkg::*;
#(
  parameter int N_COMMON = 22,
  parameter int ADDR_W   = 12,
  parameter int BANK_BIT = 8,
  localparam int W       = N_COMMON + 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_COMMON-1:0] src_i,
  input  logic                pwm_trip_i,
  input  logic                pwm_sync_i,
  input  logic                bus_wr_i,
  input  logic                bus_rd_i,
  input  logic [ADDR_W-1:0]   bus_addr_i,
  input  logic [DATA_W-1:0]   bus_wdata_i,
  output logic [DATA_W-1:0]   bus_rdata_o,
  output logic                norm_req_o,
  output logic                fast_req_o
);
  localparam logic [ADDR_W-1:0] ALLOW_MASK = ADDR_W'((1 << BANK_BIT) | 12);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // address decode
  bus_dec_t dec;
  always_comb begin
    dec.hit  = (bus_addr_i & ~ALLOW_MASK) == '0;
    dec.fast = bus_addr_i[BANK_BIT];
    dec.sel  = reg_sel_e'(bus_addr_i[3:2]);
  end

  // source routing
  logic [BANKS-1:0][W-1:0] raw;
  intc_src_map #(.N_COMMON(N_COMMON)) u_map (
    .src_i      (src_i),
    .pwm_trip_i (pwm_trip_i),
    .pwm_sync_i (pwm_sync_i),
    .raw_norm_o (raw[0]),
    .raw_fast_o (raw[1])
  );

  // banks
  logic [BANKS-1:0][W-1:0] en;
  logic [BANKS-1:0][W-1:0] stat;
  logic [BANKS-1:0]        req;
  logic [BANKS-1:0]        set_we;
  logic [BANKS-1:0]        clr_we;

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    always_comb begin
      set_we[b] = bus_wr_i && dec.hit && (dec.fast == b[0]) && (dec.sel == REG_EN);
      clr_we[b] = bus_wr_i && dec.hit && (dec.fast == b[0]) && (dec.sel == REG_CLR);
    end

    intc_bank #(.W(W)) u_bank (
      .clk      (clk),
      .rst_n    (rst_int_n),
      .raw_i    (raw[b]),
      .set_we_i (set_we[b]),
      .clr_we_i (clr_we[b]),
      .wdata_i  (bus_wdata_i[W-1:0]),
      .en_o     (en[b]),
      .stat_o   (stat[b]),
      .req_o    (req[b])
    );
  end

  assign norm_req_o = req[0];
  assign fast_req_o = req[1];

  // registered read port
  logic [DATA_W-1:0] rdata_d;
  logic [DATA_W-1:0] rdata_q;
  logic              rbank;

  always_comb begin
    rbank   = dec.fast;
    rdata_d = '0;
    if (dec.hit) begin
      unique case (dec.sel)
        REG_STAT: rdata_d = DATA_W'(stat[rbank]);
        REG_RAW:  rdata_d = DATA_W'(raw[rbank]);
        REG_EN:   rdata_d = DATA_W'(en[rbank]);
        default:  rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)    rdata_q <= '0;
    else if (bus_rd_i) rdata_q <= rdata_d;
  end
  assign bus_rdata_o = rdata_q;

  assert_upper_zero_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    bus_rdata_o[DATA_W-1:W] == '0);

  assert_rdata_hold_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    !bus_rd_i |=> $stable(bus_rdata_o));

  assert_norm_isolated_R10: assert property (@(posedge clk) disable iff (!rst_int_n)
    (set_we[0] || clr_we[0]) |=> $stable(en[1]));

  assert_fast_isolated_R10: assert property (@(posedge clk) disable iff (!rst_int_n)
    (set_we[1] || clr_we[1]) |=> $stable(en[0]));
endmodule

// File: tb/dual_bank_intc_test.sv
module dual_bank_intc_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [21:0] src;
  logic        trip, sync;
  logic        wr, rd;
  logic [11:0] addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        nreq, freq;

  int errors = 0;
  int checks = 0;
  bit done   = 0;
  logic [23:0] m_en [2];

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_bank_intc uut (
    .clk(clk), .rst_n(rst_n), .src_i(src), .pwm_trip_i(trip), .pwm_sync_i(sync),
    .bus_wr_i(wr), .bus_rd_i(rd), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .norm_req_o(nreq), .fast_req_o(freq)
  );

  function automatic logic [23:0] raw_exp(bit fast);
    logic [22:0] s;
    s = {(fast ? sync : trip), src};
    return {s, |s};
  endfunction

  function automatic logic [31:0] read_exp(logic [11:0] a);
    bit f;
    if (a[11:9] != 0 || a[7:4] != 0 || a[1:0] != 0) return 32'h0;
    f = a[8];
    case (a[3:2])
      2'd0:    return {8'h0, raw_exp(f) & m_en[f]};
      2'd1:    return {8'h0, raw_exp(f)};
      2'd2:    return {8'h0, m_en[f]};
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_reqs(string req);
    check(req, {31'h0, nreq}, {31'h0, |(raw_exp(0) & m_en[0])});
    check(req, {31'h0, freq}, {31'h0, |(raw_exp(1) & m_en[1])});
  endtask

  task automatic bus_write(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
    if (a[11:9] == 0 && a[7:4] == 0 && a[1:0] == 0) begin
      if (a[3:2] == 2'd2) m_en[a[8]] = m_en[a[8]] | d[23:0];
      if (a[3:2] == 2'd3) m_en[a[8]] = m_en[a[8]] & ~d[23:0];
    end
  endtask

  task automatic bus_read(string req, logic [11:0] a);
    logic [31:0] exp;
    @(negedge clk);
    rd = 1'b1; addr = a;
    exp = read_exp(a);
    @(negedge clk);
    rd = 1'b0;
    check(req, rdata, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    void'($urandom(32'd4711));
    m_en[0] = '0; m_en[1] = '0;
    rst_n = 1'b0; wr = 0; rd = 0; addr = 0; wdata = 0;
    src = '1; trip = 1; sync = 1;
    repeat (3) @(negedge clk);
    // R2: in reset with every line active
    check("R2", {31'h0, nreq}, 32'h0);
    check("R2", {31'h0, freq}, 32'h0);
    check("R9", rdata, 32'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R2", {31'h0, nreq}, 32'h0);
    check("R2", {31'h0, freq}, 32'h0);
    bus_read("R2", 12'h008);
    bus_read("R2", 12'h108);
    bus_read("R2", 12'h100);
    bus_read("R1", 12'h004);
    bus_read("R1", 12'h104);

    // R3 and R8: set all, upper bits read zero
    src = '0; trip = 0; sync = 0;
    bus_write(12'h008, 32'hFFFF_FFFF);
    bus_read("R3", 12'h008);
    check("R8", rdata, 32'h00FF_FFFF);
    bus_read("R10", 12'h108);
    // R4: partial clear
    bus_write(12'h00C, 32'h00F0_000F);
    bus_read("R4", 12'h008);
    check("R4", rdata, 32'h000F_FFF0);
    // R8: writes to read-only registers are ignored
    bus_write(12'h000, 32'hFFFF_FFFF);
    bus_write(12'h004, 32'h0000_0000);
    bus_write(12'h104, 32'hFFFF_FFFF);
    bus_read("R8", 12'h008);
    bus_read("R8", 12'h108);
    bus_read("R8", 12'h00C);
    bus_read("R8", 12'h10C);
    // R8: aliased or unmapped addresses
    bus_write(12'h308, 32'hFFFF_FFFF);
    bus_write(12'h118, 32'hFFFF_FFFF);
    bus_write(12'h109, 32'hFFFF_FFFF);
    bus_read("R8", 12'h108);
    check("R8", rdata, 32'h0);
    src = '1;
    bus_read("R8", 12'h014);
    check("R8", rdata, 32'h0);
    src = '0;

    // R1 / R6: bit 23 differs per bank
    bus_write(12'h108, 32'h0080_0000);
    trip = 1; sync = 0; #1;
    check_reqs("R6");
    check("R1", {31'h0, freq}, 32'h0);
    bus_read("R1", 12'h104);
    check("R1", rdata, 32'h0);
    bus_read("R1", 12'h004);
    check("R1", rdata, 32'h0080_0001);
    trip = 0; sync = 1; #1;
    check("R1", {31'h0, freq}, 32'h1);
    check("R6", {31'h0, nreq}, 32'h0);
    bus_read("R5", 12'h100);
    check("R5", rdata, 32'h0080_0000);
    sync = 0; #1;
    check("R1", {31'h0, freq}, 32'h0);

    // R1: summary bit 0 enabled alone
    bus_write(12'h10C, 32'hFFFF_FFFF);
    bus_write(12'h108, 32'h0000_0001);
    src = 22'h000020; #1;
    check("R1", {31'h0, freq}, 32'h1);
    bus_read("R5", 12'h100);
    check("R5", rdata, 32'h0000_0001);
    src = '0; #1;
    check("R1", {31'h0, freq}, 32'h0);

    // R9: no read strobe, data holds
    bus_read("R9", 12'h004);
    held = rdata;
    src = '1; trip = 1;
    repeat (3) @(negedge clk);
    check("R9", rdata, held);

    // random phase
    for (int i = 0; i < 400; i++) begin
      int op;
      logic [11:0] a;
      @(negedge clk);
      src  = 22'($urandom);
      trip = 1'($urandom);
      sync = 1'($urandom);
      #1;
      check_reqs("R6");
      op = $urandom_range(0, 5);
      a  = {3'b0, 1'($urandom), 4'b0, 2'($urandom), 2'b0};
      case (op)
        0: bus_write({a[11:4], 4'h8}, $urandom & $urandom);
        1: bus_write({a[11:4], 4'hC}, $urandom | $urandom);
        2: bus_write(12'($urandom), $urandom);
        3: bus_read("R5", a);
        4: bus_read("R8", 12'($urandom));
        default: bus_read("R7", a);
      endcase
      #1;
      check_reqs("R6");
    end
    bus_read("R3", 12'h008);
    bus_read("R4", 12'h108);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule